// File: doc/BRIEF.md
# Cartridge ROM Paging and Select Logic

This block is the glue logic on an 8-bit home-computer plug-in cartridge. The host gives each cartridge slot two ROM positions, one even and one odd. The block watches the host bus strobes and enables exactly one of the two ROM chips on the cartridge. It also owns an 8-bit bank register. The bank register drives the upper address lines of the cartridge memory, which extends what the host can reach through its paged 16 KB window at 8000h–BFFFh.

The bank register can be decoded in two ways, picked by a strap input. On the page-decode host, the register sits at the top byte of the FCxx I/O page: the page-FC strobe must be low and the low address byte must be FFh. On the dedicated-strobe host, a separate active-low strobe that the host already decodes selects the register, and the address byte plays no part. Writes are captured when the CPU clock high phase ends. Reads drive the register value onto the data bus.

A free-running sampling clock `clk` runs much faster than the CPU clock phase. It is used only to see the end of the high phase and to hold state. The reset input is asynchronous. It is brought into the `clk` domain before it is used.

Top module: `cart_pager`

## Requirements
- R1: When `host_sel` is 0, a high phase with `page_fc_n` low, `addr_lo` = FFh and `dir_rd` low loads the `data_in` value held during that phase into `bank_q`. `bank_q` shows the new value one `clk` cycle after `phi_hi` has been seen low.
- R2: When `host_sel` is 1, a high phase with `bank_stb_n` low and `dir_rd` low loads `data_in` into `bank_q` with the same timing as R1, whatever the value of `addr_lo`.
- R3: The decode path that `host_sel` does not pick is ignored. When `host_sel` is 0, `bank_stb_n` has no effect. When `host_sel` is 1, `page_fc_n` and `addr_lo` have no effect. No other access changes `bank_q`.
- R4: `rom_ce_n` bit 0 is the even ROM position and bit 1 is the odd one. When an enable is allowed, the bit whose index equals `rom_sel` goes low, and at most one bit is ever low.
- R5: A ROM chip enable is asserted only while `cs_rw` is high and the I/O strobe of the active decode path is inactive (`page_fc_n` for host 0, `bank_stb_n` for host 1).
- R6: `rom_oe_n` is low only while `oe_n` is low, `phi_hi` is high, and a ROM chip enable is asserted.
- R7: `data_oe` is high only while the bank decode hits, `dir_rd` is high and `phi_hi` is high. While it is high, `data_out` equals `bank_q`. Otherwise `data_out` is 0.
- R8: While `phi_hi` is low, `rom_ce_n` is 11b, `rom_oe_n` is 1 and `data_oe` is 0, even when `oe_n`, `cs_rw` and `dir_rd` are active.
- R9: While `dir_rd` is low (host write), `rom_ce_n` is 11b and `data_oe` is 0.
- R10: Holding `rst_n` low for at least three `clk` cycles clears `bank_q` to 0.
- R11: `bank_q` does not change during the high phase. It can change only on the `clk` edge that first sees `phi_hi` low after a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the CPU clock phase |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| host_sel | input | 1 | Host type: 0 = page-strobe plus address decode, 1 = dedicated strobe |
| phi_hi | input | 1 | CPU clock, high during the data phase |
| addr_lo | input | 8 | Low byte of the host address |
| page_fc_n | input | 1 | Active-low strobe for host page FCxx |
| bank_stb_n | input | 1 | Active-low dedicated bank-register strobe |
| cs_rw | input | 1 | Shared pin, active-high memory chip select outside the I/O region |
| dir_rd | input | 1 | Data direction, high = host reads |
| rom_sel | input | 1 | ROM-select LSB, picks the even (0) or odd (1) position |
| oe_n | input | 1 | Active-low output enable from the host |
| data_in | input | 8 | Data bus as seen by the cartridge |
| rom_ce_n | output | 2 | Active-low ROM chip enables, bit 0 even, bit 1 odd |
| rom_oe_n | output | 1 | Active-low ROM output enable |
| bank_q | output | 8 | Bank register, upper memory address bits |
| data_out | output | 8 | Value driven on the data bus |
| data_oe | output | 1 | Data-bus drive enable |

## Verification
A wrong bank value shows up at once and all the time on `bank_q`, and on `data_out` in the next read of the register. A bad capture point, such as loading while the phase is still high, shows up as `bank_q` changing during the high phase, one `clk` earlier than allowed. The enables are combinational, so a decode error shows on `rom_ce_n`, `rom_oe_n` or `data_oe` in the same cycle. The bench sweeps every pattern of strobes, direction, chip select, ROM select and output enable for both host types, at several address bytes, and checks both phases of every access.

// File: rtl/cart_pkg.sv
// Package: shared widths and the host-type encoding for the cartridge
// paging logic. Assumes an 8-bit host data bus and low address byte.
package cart_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    typedef enum logic {
        HOST_PAGE_DECODE = 1'b0,
        HOST_DEDICATED   = 1'b1
    } host_e;
endpackage

// File: rtl/cart_rst_sync.sv
// Reset synchronizer: brings the asynchronous active-low reset into the
// sampling-clock domain through STAGES flops. Assumes STAGES >= 2. The
// result is used as a synchronous active-low reset downstream.
module cart_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw reset level through the synchronizer chain.
    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], rst_n};
    end

    assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cart_bank_decode.sv
// Bank-register decode: chooses between the page-strobe plus address
// compare path and the dedicated strobe path from host_sel. Also reports
// whether the active path's I/O strobe is asserted, which marks a cycle
// in which the shared chip-select pin is not a memory select.
module cart_bank_decode #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_LOC = '1
) (
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic              page_fc_n,
    input  logic              bank_stb_n,
    output logic              bank_hit,
    output logic              io_sel
);
    import cart_pkg::*;

    host_e host;
    logic  page_hit;

    assign host = host_e'(host_sel);

    // Page-strobe path needs the strobe and the exact low address byte.
    assign page_hit = !page_fc_n && (addr_lo == REG_LOC);

    // Select the decode path that matches the host type.
    always_comb begin
        if (host == HOST_DEDICATED) begin
            bank_hit = !bank_stb_n;
            io_sel   = !bank_stb_n;
        end else begin
            bank_hit = page_hit;
            io_sel   = !page_fc_n;
        end
    end
endmodule

// File: rtl/cart_bank_reg.sv
// Bank register: holds the write request and data seen during the CPU
// clock high phase, and commits them on the first sampling edge that sees
// the phase low. Assumes clk is fast enough to sample every phase at
// least twice. Synchronous active-low reset clears the register.
module cart_bank_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_sync_n,
    input  logic              phi_hi,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] bank_q
);
    logic              phi_d;
    logic              wr_hold;
    logic [DATA_W-1:0] data_hold;
    logic              phase_end;

    assign phase_end = phi_d && !phi_hi;

    // Track the previous phase level to find the end of the high phase.
    always_ff @(posedge clk) begin
        if (!rst_sync_n) phi_d <= 1'b0;
        else             phi_d <= phi_hi;
    end

    // Hold the latest write request and data while the phase is high.
    always_ff @(posedge clk) begin
        if (!rst_sync_n) begin
            wr_hold   <= 1'b0;
            data_hold <= '0;
        end else if (phi_hi) begin
            wr_hold   <= wr_req;
            data_hold <= data_in;
        end
    end

    // Commit a held write when the high phase ends.
    always_ff @(posedge clk) begin
        if (!rst_sync_n)              bank_q <= '0;
        else if (phase_end && wr_hold) bank_q <= data_hold;
    end
endmodule

// File: rtl/cart_rom_select.sv
// ROM select: makes one active-low chip enable per ROM position from the
// shared chip-select pin, the direction pin, the clock phase and the
// ROM-select bits, plus a phase-qualified output enable. Assumes the
// host's output-enable input may be low outside the high phase.
module cart_rom_select #(
    parameter int SEL_W = 1,
    localparam int N_ROM = 1 << SEL_W
) (
    input  logic             phi_hi,
    input  logic             cs_rw,
    input  logic             dir_rd,
    input  logic             io_sel,
    input  logic [SEL_W-1:0] rom_sel,
    input  logic             oe_n,
    output logic [N_ROM-1:0] rom_ce_n,
    output logic             rom_oe_n
);
    logic mem_read;

    // A memory read needs the select, read direction, no I/O strobe, high phase.
    assign mem_read = cs_rw && dir_rd && !io_sel && phi_hi;

    for (genvar i = 0; i < N_ROM; i++) begin : g_ce
        // Enable only the position whose index matches rom_sel.
        assign rom_ce_n[i] = !(mem_read && (rom_sel == SEL_W'(i)));
    end

    // Output enable follows the host strobe only inside an enabled read.
    assign rom_oe_n = !(mem_read && !oe_n);
endmodule

// File: rtl/cart_pager.sv
// Top: cartridge ROM paging and select logic. Decodes the bank register
// for either host type, captures writes at the end of the CPU clock high
// phase, drives register reads onto the data bus and enables one of the
// slot's two ROMs. Assumes clk samples phi_hi several times per phase.
module cart_pager #(
    parameter int                                 DATA_W   = cart_pkg::DATA_W,
    parameter int                                 ADDR_W   = cart_pkg::ADDR_W,
    parameter int                                 SEL_W    = 1,
    parameter logic [cart_pkg::ADDR_W-1:0]        REG_LOC  = 8'hFF,
    parameter int                                 SYNC_STG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel,
    input  logic                  phi_hi,
    input  logic [ADDR_W-1:0]     addr_lo,
    input  logic                  page_fc_n,
    input  logic                  bank_stb_n,
    input  logic                  cs_rw,
    input  logic                  dir_rd,
    input  logic [SEL_W-1:0]      rom_sel,
    input  logic                  oe_n,
    input  logic [DATA_W-1:0]     data_in,
    output logic [(1<<SEL_W)-1:0] rom_ce_n,
    output logic                  rom_oe_n,
    output logic [DATA_W-1:0]     bank_q,
    output logic [DATA_W-1:0]     data_out,
    output logic                  data_oe
);
    logic rst_sync_n;
    logic bank_hit;
    logic io_sel;
    logic wr_req;

    cart_rst_sync #(.STAGES(SYNC_STG)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    cart_bank_decode #(.ADDR_W(ADDR_W), .REG_LOC(REG_LOC)) u_dec (
        .host_sel   (host_sel),
        .addr_lo    (addr_lo),
        .page_fc_n  (page_fc_n),
        .bank_stb_n (bank_stb_n),
        .bank_hit   (bank_hit),
        .io_sel     (io_sel)
    );

    // A register write is a decode hit while the host drives the bus.
    assign wr_req = bank_hit && !dir_rd;

    cart_bank_reg #(.DATA_W(DATA_W)) u_reg (
        .clk        (clk),
        .rst_sync_n (rst_sync_n),
        .phi_hi     (phi_hi),
        .wr_req     (wr_req),
        .data_in    (data_in),
        .bank_q     (bank_q)
    );

    cart_rom_select #(.SEL_W(SEL_W)) u_rom (
        .phi_hi   (phi_hi),
        .cs_rw    (cs_rw),
        .dir_rd   (dir_rd),
        .io_sel   (io_sel),
        .rom_sel  (rom_sel),
        .oe_n     (oe_n),
        .rom_ce_n (rom_ce_n),
        .rom_oe_n (rom_oe_n)
    );

    // Drive the register onto the bus only for a high-phase register read.
    assign data_oe  = bank_hit && dir_rd && phi_hi;
    assign data_out = data_oe ? bank_q : '0;
endmodule

// File: rtl/cart_pager_chk.sv
// Checker: port-level properties of cart_pager, bound to every instance.
// Assumes the default single-bit ROM select (two ROM positions).
module cart_pager_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_sel,
    input logic                  phi_hi,
    input logic [ADDR_W-1:0]     addr_lo,
    input logic                  page_fc_n,
    input logic                  bank_stb_n,
    input logic                  cs_rw,
    input logic                  dir_rd,
    input logic [SEL_W-1:0]      rom_sel,
    input logic                  oe_n,
    input logic [DATA_W-1:0]     data_in,
    input logic [(1<<SEL_W)-1:0] rom_ce_n,
    input logic                  rom_oe_n,
    input logic [DATA_W-1:0]     bank_q,
    input logic [DATA_W-1:0]     data_out,
    input logic                  data_oe
);
    logic io_active;
    assign io_active = host_sel ? !bank_stb_n : !page_fc_n;

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rom_ce_n));                                                 // R4
    AST_CE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rw || io_active) |-> (&rom_ce_n));                               // R5
    AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (!oe_n && phi_hi && !(&rom_ce_n)));                     // R6
    AST_DRIVE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out == bank_q && dir_rd && phi_hi));                // R7
    AST_LOW_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !phi_hi |-> ((&rom_ce_n) && rom_oe_n && !data_oe));                   // R8
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rd |-> ((&rom_ce_n) && !data_oe));                               // R9
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phi_hi || !$past(phi_hi)) |=> $stable(bank_q));                      // R11

    logic unused_ok;
    assign unused_ok = ^{addr_lo, data_in};
endmodule

bind cart_pager cart_pager_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .phi_hi     (phi_hi),
    .addr_lo    (addr_lo),
    .page_fc_n  (page_fc_n),
    .bank_stb_n (bank_stb_n),
    .cs_rw      (cs_rw),
    .dir_rd     (dir_rd),
    .rom_sel    (rom_sel),
    .oe_n       (oe_n),
    .data_in    (data_in),
    .rom_ce_n   (rom_ce_n),
    .rom_oe_n   (rom_oe_n),
    .bank_q     (bank_q),
    .data_out   (data_out),
    .data_oe    (data_oe)
);

// File: tb/cart_pager_tb.sv
// Bench: sweeps strobes, direction, select and output enable over both
// host types and several address bytes, with a bench-side bank model.
module cart_pager_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic       phi_hi = 1'b0;
    logic [7:0] addr_lo = 8'h00;
    logic       page_fc_n = 1'b1;
    logic       bank_stb_n = 1'b1;
    logic       cs_rw = 1'b0;
    logic       dir_rd = 1'b1;
    logic [0:0] rom_sel = 1'b0;
    logic       oe_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic [1:0] rom_ce_n;
    logic       rom_oe_n;
    logic [7:0] bank_q;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] ref_bank = 8'h00;

    always #10 clk = ~clk;

    cart_pager u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .phi_hi(phi_hi),
        .addr_lo(addr_lo), .page_fc_n(page_fc_n), .bank_stb_n(bank_stb_n),
        .cs_rw(cs_rw), .dir_rd(dir_rd), .rom_sel(rom_sel), .oe_n(oe_n),
        .data_in(data_in), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .bank_q(bank_q), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One host access: low phase, high phase, then the next low phase.
    task automatic access(input logic h, input logic [7:0] a, input logic fc, input logic stb,
                          input logic cs, input logic dr, input logic sel, input logic oe,
                          input logic [7:0] d);
        logic hit, io, mem;
        logic [1:0] exp_ce;
        @(negedge clk);
        phi_hi = 1'b0; host_sel = h; addr_lo = a; page_fc_n = fc; bank_stb_n = stb;
        cs_rw = cs; dir_rd = dr; rom_sel = sel; oe_n = oe; data_in = d;
        @(negedge clk);
        phi_hi = 1'b1;
        @(negedge clk);
        @(negedge clk);
        hit = h ? !stb : (!fc && a == 8'hFF);
        io  = h ? !stb : !fc;
        mem = cs && dr && !io;
        exp_ce = mem ? (sel ? 2'b01 : 2'b10) : 2'b11;
        check(dr ? "R4/R5 ce" : "R9 ce", {30'd0, rom_ce_n}, {30'd0, exp_ce});
        check("R6 oe", {31'd0, rom_oe_n}, {31'd0, !(mem && !oe)});
        check(dr ? "R7 drive" : "R9 drive", {31'd0, data_oe}, {31'd0, hit && dr});
        check("R7 data", {24'd0, data_out}, {24'd0, (hit && dr) ? ref_bank : 8'h00});
        check("R11 hold", {24'd0, bank_q}, {24'd0, ref_bank});
        phi_hi = 1'b0;
        if (hit && !dr) ref_bank = d;
        @(negedge clk);
        check("R8 quiet", {29'd0, rom_ce_n, rom_oe_n}, {29'd0, 2'b11, 1'b1});
        check("R8 nodrive", {31'd0, data_oe}, 32'd0);
        check(hit ? (h ? "R2 load" : "R1 load") : "R3 ignore", {24'd0, bank_q}, {24'd0, ref_bank});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [4];
        int n;
        addrs[0] = 8'hFF; addrs[1] = 8'hFE; addrs[2] = 8'h00; addrs[3] = 8'h7F;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset bank", {24'd0, bank_q}, 32'd0);
        check("R8 reset quiet", {29'd0, rom_ce_n, rom_oe_n}, {29'd0, 3'b111});
        n = 0;
        for (int h = 0; h < 2; h++)
            for (int ai = 0; ai < 4; ai++)
                for (int m = 0; m < 64; m++) begin
                    n++;
                    access(h[0], addrs[ai], m[0], m[1], m[2], m[3], m[4], m[5],
                           8'((n * 37 + 11) & 8'hFF));
                end
        // R1 and R2 directed loads followed by read-back on the bus.
        access(1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5);
        access(1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        access(1'b1, 8'h12, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C);
        access(1'b1, 8'h12, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        check("R2 final bank", {24'd0, bank_q}, 32'h3C);
        // R10: reset in the middle of operation clears the register.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 mid reset", {24'd0, bank_q}, 32'd0);
        rst_n = 1'b1;
        ref_bank = 8'h00;
        repeat (3) @(negedge clk);
        access(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule